// File: doc/BRIEF.md
# Commit-Point Exception and Interrupt Controller

This block governs trap handling for a single-issue, in-order pipeline with five stages. Every instruction entering from fetch gets a small tag made of a valid bit, its PC, a pending-trap bit and a 3-bit trap code. The tag moves forward through the decode, execute and memory pipeline registers. A fault that a stage detects is recorded in the tag but does not act on its own. The memory stage is the only place where a trap is taken. When the instruction there carries a pending trap, raises a data address fault, or an external interrupt request is present, the block takes the trap in that cycle. Taking the trap does four things:
- it suppresses the committing instruction's writeback;
- it flushes every younger instruction held in the tag pipeline;
- it loads the trap-code and trap-PC registers;
- on the next cycle it asks fetch to restart at a fixed handler address.

The block sits next to the stage datapaths and follows their lock-step movement. Fetch presents `if_valid_i` and `if_pc_i` together with any fetch-address fault. Each later stage reports the fault it sees for the instruction it holds in that cycle. The datapath uses `commit_o` as its writeback enable and `take_o` as its flush. The asynchronous reset is released through a two-flop synchronizer, so the block starts working two clock edges after `rst_n` rises.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While reset is applied, and for the cycles after release, `commit_o`, `take_o` and `redirect_o` are 0, and `cause_o` and `epc_o` are 0.
- R2: An instruction accepted from fetch with no fault appears in the memory stage three cycles later. In that cycle `commit_o` is 1, and `cause_o`/`epc_o` do not change.
- R3: A fetch-address fault travels with its instruction. When that instruction reaches the memory stage, the trap is taken with code 1 and the trap PC is the instruction's own PC.
- R4: `id_illegal_i`, raised while an instruction is in decode, leads to a trap with code 2 when that instruction reaches the memory stage.
- R5: `ex_ovf_i`, raised while an instruction is in execute, leads to a trap with code 3 one cycle later, when that instruction reaches the memory stage.
- R6: `mem_fault_i`, raised while an instruction is in the memory stage, takes the trap in that same cycle with code 4.
- R7: When one instruction collects faults in several stages, the recorded code is the one from the earliest stage (fetch, then decode, then execute, then memory).
- R8: `irq_i` in a cycle where the memory stage holds a valid instruction takes a trap with code 5, whatever synchronous faults that instruction has, and the trap PC is that instruction's PC. `irq_i` with an empty memory stage has no effect.
- R9: In the cycle a trap is taken, `commit_o` is 0. None of the instructions that were in fetch, decode or execute in that cycle ever reaches commit.
- R10: `redirect_o` is 1 exactly in the cycle after a trap is taken, and `redirect_pc_o` then equals the handler address parameter.
- R11: Faults reported for a stage that holds no valid instruction never cause a trap and never change `cause_o` or `epc_o`.
- R12: `cause_o` and `epc_o` hold their values until the next trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid_i | input | 1 | Fetch delivers an instruction this cycle |
| if_pc_i | input | PC_W | PC of the fetched instruction |
| if_fault_i | input | 1 | Fetch address fault for the fetched instruction |
| id_illegal_i | input | 1 | Illegal opcode detected for the instruction in decode |
| ex_ovf_i | input | 1 | Arithmetic overflow for the instruction in execute |
| mem_fault_i | input | 1 | Data address fault for the instruction in the memory stage |
| irq_i | input | 1 | External interrupt request |
| commit_o | output | 1 | Memory-stage instruction commits (writeback enable) |
| take_o | output | 1 | Trap taken this cycle; flushes all stages and writeback |
| redirect_o | output | 1 | Fetch must restart at the handler address this cycle |
| redirect_pc_o | output | PC_W | Handler address presented with redirect_o |
| cause_o | output | 3 | Trap-code register |
| epc_o | output | PC_W | Trap-PC register |

## Verification
Some properties are checked on every cycle:
- a trap is always followed by a single-cycle redirect to the handler address;
- the cycle after a trap is an empty memory stage, with neither commit nor trap;
- the trap-PC register captures the PC held in the memory stage;
- an interrupt trap always records code 5;
- both trap registers stay unchanged when no trap is taken.

Other behaviour depends on instruction sequences and only the bench scenarios exercise it:
- which code wins when one instruction collects several faults;
- that faults only count when they are aligned to a valid instruction;
- that younger instructions flushed by a trap never commit.

The bench model follows every instruction as an entry in a queue and predicts commit, trap, code and PC on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_IFETCH  = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_OVF     = 3'd3,
    CAUSE_DADDR   = 3'd4,
    CAUSE_IRQ     = 3'd5
  } cause_e;
endpackage

// File: rtl/exc_stage_reg.sv
// One pipeline register of the trap tag. An older pending trap wins over a
// fault detected in the stage the instruction is leaving.
module exc_stage_reg #(
  parameter int            PC_W       = 32,
  parameter int            CW         = 3,
  parameter logic [CW-1:0] LOCAL_CODE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_pend,
  input  logic [CW-1:0]   up_code,
  input  logic            local_fault,
  output logic            dn_valid,
  output logic [PC_W-1:0] dn_pc,
  output logic            dn_pend,
  output logic [CW-1:0]   dn_code
);
  logic          load;
  logic          nxt_valid;
  logic          nxt_pend;
  logic [CW-1:0] nxt_code;

  always_comb begin
    load      = up_valid & ~flush;
    nxt_valid = load;
    nxt_pend  = load & (up_pend | local_fault);
    if (up_pend)          nxt_code = up_code;
    else if (local_fault) nxt_code = LOCAL_CODE;
    else                  nxt_code = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_pend  <= 1'b0;
      dn_pc    <= '0;
      dn_code  <= '0;
    end else begin
      dn_valid <= nxt_valid;
      dn_pend  <= nxt_pend;
      if (load) begin
        dn_pc   <= up_pc;
        dn_code <= nxt_code;
      end
    end
  end
endmodule

// File: rtl/exc_commit.sv
// Commit-point decision: interrupt first, then the carried trap, then the
// data address fault of the memory stage itself.
module exc_commit
  import exc_pkg::*;
(
  input  logic               m_valid,
  input  logic               m_pend,
  input  logic [CAUSE_W-1:0] m_code,
  input  logic               mem_fault,
  input  logic               irq,
  output logic               take,
  output logic               commit,
  output logic [CAUSE_W-1:0] cause
);
  cause_e sel;

  always_comb begin
    if (irq)            sel = CAUSE_IRQ;
    else if (m_pend)    sel = cause_e'(m_code);
    else if (mem_fault) sel = CAUSE_DADDR;
    else                sel = CAUSE_NONE;
    take   = m_valid & (irq | m_pend | mem_fault);
    commit = m_valid & ~(irq | m_pend | mem_fault);
    cause  = sel;
  end
endmodule

// File: rtl/exc_csr.sv
// Trap-code and trap-PC registers plus the one-cycle fetch redirect.
module exc_csr #(
  parameter int              PC_W       = 32,
  parameter int              CW         = 3,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [CW-1:0]   cause_in,
  input  logic [PC_W-1:0] epc_in,
  output logic [CW-1:0]   cause_q,
  output logic [PC_W-1:0] epc_q,
  output logic            redirect_q,
  output logic [PC_W-1:0] redirect_pc_q
);
  logic [CW-1:0]   cause_d;
  logic [PC_W-1:0] epc_d;
  logic [PC_W-1:0] rpc_d;

  always_comb begin
    cause_d = take ? cause_in : cause_q;
    epc_d   = take ? epc_in : epc_q;
    rpc_d   = take ? HANDLER_PC : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q       <= '0;
      epc_q         <= '0;
      redirect_q    <= 1'b0;
      redirect_pc_q <= '0;
    end else begin
      cause_q       <= cause_d;
      epc_q         <= epc_d;
      redirect_q    <= take;
      redirect_pc_q <= rpc_d;
    end
  end
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h8000_0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               if_valid_i,
  input  logic [PC_W-1:0]    if_pc_i,
  input  logic               if_fault_i,
  input  logic               id_illegal_i,
  input  logic               ex_ovf_i,
  input  logic               mem_fault_i,
  input  logic               irq_i,
  output logic               commit_o,
  output logic               take_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    epc_o
);
  localparam int NREG = 3;
  localparam int CW   = CAUSE_W;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NREG:0]           st_v;
  logic [NREG:0]           st_p;
  logic [NREG:0][PC_W-1:0] st_pc;
  logic [NREG:0][CW-1:0]   st_code;
  logic [NREG-1:0]         lf;
  logic                    take;
  logic [CW-1:0]           cause_sel;

  assign st_v[0]    = if_valid_i;
  assign st_p[0]    = 1'b0;
  assign st_pc[0]   = if_pc_i;
  assign st_code[0] = '0;
  assign lf         = {ex_ovf_i, id_illegal_i, if_fault_i};

  for (genvar i = 0; i < NREG; i++) begin : g_stage
    localparam logic [CW-1:0] CODE_I = CW'(i + 1);
    exc_stage_reg #(.PC_W(PC_W), .CW(CW), .LOCAL_CODE(CODE_I)) u_reg (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .flush       (take),
      .up_valid    (st_v[i]),
      .up_pc       (st_pc[i]),
      .up_pend     (st_p[i]),
      .up_code     (st_code[i]),
      .local_fault (lf[i]),
      .dn_valid    (st_v[i+1]),
      .dn_pc       (st_pc[i+1]),
      .dn_pend     (st_p[i+1]),
      .dn_code     (st_code[i+1])
    );
  end

  exc_commit u_commit (
    .m_valid   (st_v[NREG]),
    .m_pend    (st_p[NREG]),
    .m_code    (st_code[NREG]),
    .mem_fault (mem_fault_i),
    .irq       (irq_i),
    .take      (take),
    .commit    (commit_o),
    .cause     (cause_sel)
  );

  exc_csr #(.PC_W(PC_W), .CW(CW), .HANDLER_PC(HANDLER_PC)) u_csr (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .take          (take),
    .cause_in      (cause_sel),
    .epc_in        (st_pc[NREG]),
    .cause_q       (cause_o),
    .epc_q         (epc_o),
    .redirect_q    (redirect_o),
    .redirect_pc_q (redirect_pc_o)
  );

  assign take_o = take;
endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_o,
  input logic            commit_o,
  input logic            irq_i,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic [2:0]      cause_o,
  input logic [PC_W-1:0] epc_o,
  input logic [PC_W-1:0] m_pc
);
  assert_redirect_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (redirect_o && redirect_pc_o == HANDLER_PC));

  assert_redirect_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> !redirect_o);

  assert_flushed_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (!commit_o && !take_o));

  assert_epc_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (epc_o == $past(m_pc)));

  assert_irq_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && irq_i) |=> (cause_o == 3'd5));

  assert_regs_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> ($stable(cause_o) && $stable(epc_o)));
endmodule

bind exc_commit_ctrl exc_commit_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .take_o        (take_o),
  .commit_o      (commit_o),
  .irq_i         (irq_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .cause_o       (cause_o),
  .epc_o         (epc_o),
  .m_pc          (st_pc[3])
);

// File: tb/exc_commit_ctrl_bench.sv
module exc_commit_ctrl_bench;
  localparam int          PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h8000_0100;

  logic clk = 1'b0;
  logic rst_n;
  logic if_valid_i, if_fault_i, id_illegal_i, ex_ovf_i, mem_fault_i, irq_i;
  logic [PC_W-1:0] if_pc_i;
  logic commit_o, take_o, redirect_o;
  logic [PC_W-1:0] redirect_pc_o, epc_o;
  logic [2:0] cause_o;

  always #10 clk = ~clk;

  exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) u_exc_commit_ctrl (
    .clk(clk), .rst_n(rst_n),
    .if_valid_i(if_valid_i), .if_pc_i(if_pc_i), .if_fault_i(if_fault_i),
    .id_illegal_i(id_illegal_i), .ex_ovf_i(ex_ovf_i), .mem_fault_i(mem_fault_i),
    .irq_i(irq_i), .commit_o(commit_o), .take_o(take_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .cause_o(cause_o), .epc_o(epc_o)
  );

  typedef struct { logic [31:0] pc; int code; int stage; } ent_t;
  ent_t q[$];
  int          m_cause;
  logic [31:0] m_epc;
  bit          m_redir;
  int checks = 0, failures = 0, obs_commits = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit fv, input logic [31:0] pc, input bit ff,
                      input bit ill, input bit ovf, input bit mf, input bit irq);
    int mi; bit e_take, e_commit; int e_code;
    @(negedge clk);
    if_valid_i = fv; if_pc_i = pc; if_fault_i = ff;
    id_illegal_i = ill; ex_ovf_i = ovf; mem_fault_i = mf; irq_i = irq;
    #1;
    mi = -1;
    foreach (q[k]) if (q[k].stage == 3) mi = k;
    e_take = 0; e_commit = 0; e_code = 0;
    if (mi >= 0) begin
      if (irq)                   e_code = 5;
      else if (q[mi].code != 0)  e_code = q[mi].code;
      else if (mf)               e_code = 4;
      e_take   = (e_code != 0);
      e_commit = !e_take;
    end
    if (commit_o) obs_commits++;
    chk(commit_o == e_commit, cur_req, "commit_o", commit_o, e_commit);
    chk(take_o == e_take, cur_req, "take_o", take_o, e_take);
    chk(redirect_o == m_redir, "R10", "redirect_o", redirect_o, m_redir);
    if (m_redir) chk(redirect_pc_o == HANDLER, "R10", "redirect_pc_o", redirect_pc_o, HANDLER);
    chk(cause_o == 3'(m_cause), "R12", "cause_o", cause_o, m_cause);
    chk(epc_o == m_epc, "R12", "epc_o", epc_o, m_epc);
    if (e_take) begin
      m_cause = e_code; m_epc = q[mi].pc; m_redir = 1;
      q.delete();
    end else begin
      ent_t nq[$];
      m_redir = 0;
      foreach (q[k]) begin
        ent_t e = q[k];
        if (e.stage == 1 && e.code == 0 && ill) e.code = 2;
        if (e.stage == 2 && e.code == 0 && ovf) e.code = 3;
        if (e.stage < 3) begin e.stage++; nq.push_back(e); end
      end
      if (fv) nq.push_back('{pc: pc, code: (ff ? 1 : 0), stage: 1});
      q = nq;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    rst_n = 0; if_valid_i = 0; if_pc_i = 0; if_fault_i = 0;
    id_illegal_i = 0; ex_ovf_i = 0; mem_fault_i = 0; irq_i = 0;
    m_cause = 0; m_epc = 0; m_redir = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    chk(!commit_o && !take_o && !redirect_o, "R1", "ctrl outs in reset",
        {commit_o, take_o, redirect_o}, 0);
    chk(cause_o == 0 && epc_o == 0, "R1", "regs in reset", epc_o, 0);
    rst_n = 1;
    cur_req = "R1"; idle(4);

    cur_req = "R2";
    step(1, 32'h1000, 0, 0, 0, 0, 0);
    step(1, 32'h1004, 0, 0, 0, 0, 0);
    step(1, 32'h1008, 0, 0, 0, 0, 0);
    idle(4);
    chk(obs_commits == 3, "R2", "clean commits", obs_commits, 3);

    cur_req = "R3";
    step(1, 32'h2000, 1, 0, 0, 0, 0);
    step(1, 32'h2004, 0, 0, 0, 0, 0);
    idle(4);
    chk(cause_o == 1 && epc_o == 32'h2000, "R3", "fetch fault trap", epc_o, 32'h2000);

    cur_req = "R4";
    step(1, 32'h3000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    idle(4);
    chk(cause_o == 2 && epc_o == 32'h3000, "R4", "illegal trap", cause_o, 2);

    cur_req = "R5";
    step(1, 32'h3100, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    idle(3);
    chk(cause_o == 3 && epc_o == 32'h3100, "R5", "overflow trap", cause_o, 3);

    cur_req = "R6";
    step(1, 32'h3200, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 1, 0);
    idle(2);
    chk(cause_o == 4 && epc_o == 32'h3200, "R6", "data fault trap", cause_o, 4);

    cur_req = "R7";
    step(1, 32'h4000, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    idle(2);
    chk(cause_o == 1, "R7", "fetch beats later faults", cause_o, 1);
    step(1, 32'h4100, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    idle(2);
    chk(cause_o == 2, "R7", "illegal beats overflow and data fault", cause_o, 2);

    cur_req = "R8";
    step(1, 32'h5000, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 1, 1);
    idle(2);
    chk(cause_o == 5 && epc_o == 32'h5000, "R8", "irq overrides data fault", cause_o, 5);
    step(1, 32'h5100, 1, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 0, 1);
    idle(2);
    chk(cause_o == 5 && epc_o == 32'h5100, "R8", "irq overrides carried fault", epc_o, 32'h5100);
    step(0, 0, 0, 0, 0, 0, 1);
    chk(take_o == 0, "R8", "irq with empty memory stage", take_o, 0);
    idle(2);

    cur_req = "R9";
    step(1, 32'h6000, 0, 0, 0, 0, 0);
    step(1, 32'h6004, 0, 0, 0, 0, 0);
    step(1, 32'h6008, 0, 0, 0, 0, 0);
    step(1, 32'h600c, 0, 0, 0, 1, 0);
    base = obs_commits;
    idle(5);
    chk(obs_commits == base, "R9", "flushed instructions commit", obs_commits - base, 0);
    chk(cause_o == 4 && epc_o == 32'h6000, "R9", "oldest trapped", epc_o, 32'h6000);

    cur_req = "R11";
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 32'h7000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    idle(4);
    chk(cause_o == 4 && epc_o == 32'h6000, "R11", "bubble faults ignored", cause_o, 4);

    cur_req = "R12";
    step(1, 32'h7100, 0, 0, 0, 0, 0);
    step(1, 32'h7104, 0, 0, 0, 0, 0);
    idle(4);
    chk(cause_o == 4 && epc_o == 32'h6000, "R12", "regs held across commits", epc_o, 32'h6000);

    cur_req = "R10";
    step(1, 32'h7200, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 0, 1);
    step(1, HANDLER, 0, 0, 0, 0, 0);
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule